// File: doc/BRIEF.md
# DRAM Memory Cycle Sequencer

This block times a single DRAM access once an arbiter has granted it. It places the row address and then the column address on a shared address bus. It drives the row and column strobes and raises one write enable per byte lane. On writes it produces an even parity bit for each byte. On reads it captures the returned word and checks every enabled byte against its stored parity bit. A plain access lasts eight phases, and one phase is one clock.

An access can be started speculatively, before the processor has shown that it really wants memory. The block then looks at the processor address strobe at the end of the third phase. If the strobe is present, the access continues unchanged. If it is absent, the access is abandoned before the column strobe or any write enable is asserted. The arbiter is told that the slot is over, so it can poll again.

A stretch input holds the access in its final column phase for as long as it stays high. This lets slow devices keep pace with the access. After every access, a precharge phase keeps the block from accepting new work.

The states are:
- IDLE: ready for a new access.
- ROW: phases 1 to 3, row strobe low.
- COL: phases 4 to 7, column strobe low.
- FIN: phase 8, completion.
- KILL: abandoned speculative access.
- PRE: precharge.

The transitions are:
- IDLE to ROW on an accepted start.
- ROW to KILL at the end of phase 3 when the access is speculative and the strobe is low.
- ROW to COL at the end of phase 3 otherwise.
- COL stays in COL at phase 7 while stretch is high.
- COL to FIN when stretch is low at phase 7.
- FIN to PRE.
- KILL to PRE.
- PRE to IDLE.

Top module: `dram_cycle_seq`

## Requirements
- R1: After reset, `ready` is 1, `ras_n`, `cas_n` and all `we_n` bits are 1, and `done`, `killed` and `par_err` are 0.
- R2: A start accepted at clock edge t drives `ras_n` low from edge t to edge t+7, covering phases 1 to 7. `done` is high for exactly the one phase after edge t+7, which is phase 8, and `ras_n` is high then.
- R3: `dram_addr` carries address bits [17:9] (the row) in phases 1 and 2. It carries bits [8:0] (the column) from phase 3 to the end of the column phases.
- R4: `cas_n` is low exactly in phases 4 to 7, plus any stretch phases, and never while `ras_n` is high.
- R5: On a write (`wr`=1), `we_n[i]` is low during the column phases only for the lanes with `byte_en[i]`=1. Lane i is bits [8i+7:8i]. On a read, all `we_n` bits stay high.
- R6: During the column phases, `dram_wpar[i]` equals the XOR of write byte i, so each byte plus its bit holds an even number of ones.
- R7: On a read, `rdata` holds the word present at the end of the last column phase. `par_err` is high only in phase 8 of a read, and only when some enabled lane i has an odd count of ones across `dram_rd` byte i and `dram_rpar[i]`.
- R8: If a speculative access (`spec`=1) sees `cpu_as`=0 at edge t+3, then from that edge `ras_n` is high and `done` and `killed` are high for one phase. No `cas_n` or `we_n` assertion occurs during that access.
- R9: A speculative access that sees `cpu_as`=1 at edge t+3 behaves exactly like a non-speculative one.
- R10: Each clock edge in phase 7 at which `stretch` is 1 keeps `cas_n` low for one more phase. Phase 8 follows the first phase-7 edge with `stretch` at 0.
- R11: After phase 8, or after the kill phase, one precharge phase follows with `ready` low. `ready` returns in the next phase. `start` is ignored whenever `ready` is 0, so `ras_n` stays high for at least two phases between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arbiter grant; taken only while ready |
| spec | input | 1 | Access is speculative and needs confirmation |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Row in [17:9], column in [8:0] |
| byte_en | input | 4 | Per-lane access enable |
| wdata | input | 32 | Write word |
| cpu_as | input | 1 | Processor address strobe, active high |
| stretch | input | 1 | Hold the last column phase |
| ready | output | 1 | Able to accept a start |
| done | output | 1 | Access slot finished (completed or killed) |
| killed | output | 1 | Speculative access abandoned |
| par_err | output | 1 | Read parity mismatch, valid in phase 8 |
| rdata | output | 32 | Captured read word |
| dram_addr | output | 9 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 4 | Per-lane write enables, active low |
| dram_wd | output | 32 | Write data to the array |
| dram_wpar | output | 4 | Write parity to the array |
| dram_rd | input | 32 | Read data from the array |
| dram_rpar | input | 4 | Read parity from the array |

## Verification
The latencies follow from the accepting edge t:
- The strobes and the address change in the phase after t.
- The confirmation decision takes effect right after edge t+3.
- `done`, `rdata` and `par_err` appear after edge t+7, or later by one phase for every stretched edge.

The bench keeps a behavioural phase counter that advances on the same edges as the design. Each output is sampled 2 ns after the rising edge and compared against the counter's expected value in that same phase. This way, a result one phase early or one phase late shows up as a mismatch. Separate end-of-sequence checks count the column phases of a stretched access, the completion pulses while start is held high, and read-back data after killed and confirmed writes.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_FIN,
        ST_KILL,
        ST_PRE
    } dsq_state_e;
endpackage

// File: rtl/dsq_fsm.sv
module dsq_fsm
    import dsq_pkg::*;
#(
    parameter int PH_W       = 4,
    parameter int CONFIRM_PH = 3,
    parameter int CAS_LAST   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            spec_q,
    input  logic            cpu_as,
    input  logic            stretch,
    output dsq_state_e      state,
    output logic            ras_act,
    output logic            cas_act,
    output logic            col_sel,
    output logic            done,
    output logic            killed,
    output logic            ready,
    output logic            capture
);
    localparam logic [PH_W-1:0] PH_CONF = PH_W'(CONFIRM_PH);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CAS_LAST);

    dsq_state_e      nxt;
    logic [PH_W-1:0] ph, nph;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= '0;
        end else begin
            state <= nxt;
            ph    <= nph;
        end
    end

    always_comb begin
        nxt = state;
        nph = ph;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt = ST_ROW;
                    nph = PH_W'(1);
                end
            end
            ST_ROW: begin
                if (ph == PH_CONF) begin
                    if (spec_q && !cpu_as) begin
                        nxt = ST_KILL;
                    end else begin
                        nxt = ST_COL;
                        nph = ph + 1'b1;
                    end
                end else begin
                    nph = ph + 1'b1;
                end
            end
            ST_COL: begin
                if (ph == PH_LAST) begin
                    if (!stretch) begin
                        nxt = ST_FIN;
                        nph = ph + 1'b1;
                    end
                end else begin
                    nph = ph + 1'b1;
                end
            end
            ST_FIN:  nxt = ST_PRE;
            ST_KILL: nxt = ST_PRE;
            ST_PRE:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ras_act = (state == ST_ROW) || (state == ST_COL);
        cas_act = (state == ST_COL);
        col_sel = (state == ST_COL) || ((state == ST_ROW) && (ph >= PH_CONF));
        done    = (state == ST_FIN) || (state == ST_KILL);
        killed  = (state == ST_KILL);
        ready   = (state == ST_IDLE);
        capture = (state == ST_COL) && (ph == PH_LAST) && !stretch;
    end
endmodule

// File: rtl/dsq_parity.sv
module dsq_parity #(
    parameter int NB = 4,
    localparam int DW = 8 * NB
) (
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rd,
    input  logic [NB-1:0] rpar,
    input  logic [NB-1:0] lane_en,
    output logic [NB-1:0] wpar,
    output logic          err
);
    logic [NB-1:0] lane_bad;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign wpar[g]     = ^wdata[8*g +: 8];
        assign lane_bad[g] = lane_en[g] & ((^rd[8*g +: 8]) ^ rpar[g]);
    end

    assign err = |lane_bad;
endmodule

// File: rtl/dsq_addr_mux.sv
module dsq_addr_mux #(
    parameter int AW = 9
) (
    input  logic [2*AW-1:0] addr_q,
    input  logic            col_sel,
    output logic [AW-1:0]   dram_addr
);
    always_comb begin
        if (col_sel) dram_addr = addr_q[AW-1:0];
        else         dram_addr = addr_q[2*AW-1:AW];
    end
endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
    import dsq_pkg::*;
#(
    parameter int AW = 9,
    parameter int NB = 4,
    localparam int DW = 8 * NB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            spec,
    input  logic            wr,
    input  logic [2*AW-1:0] addr,
    input  logic [NB-1:0]   byte_en,
    input  logic [DW-1:0]   wdata,
    input  logic            cpu_as,
    input  logic            stretch,
    output logic            ready,
    output logic            done,
    output logic            killed,
    output logic            par_err,
    output logic [DW-1:0]   rdata,
    output logic [AW-1:0]   dram_addr,
    output logic            ras_n,
    output logic            cas_n,
    output logic [NB-1:0]   we_n,
    output logic [DW-1:0]   dram_wd,
    output logic [NB-1:0]   dram_wpar,
    input  logic [DW-1:0]   dram_rd,
    input  logic [NB-1:0]   dram_rpar
);
    dsq_state_e      state;
    logic            ras_act, cas_act, col_sel, capture, accept, perr_now;
    logic            spec_q, wr_q, perr_q;
    logic [2*AW-1:0] addr_q;
    logic [NB-1:0]   be_q;
    logic [DW-1:0]   wdata_q, rdata_q;

    assign accept = start && ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q  <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            perr_q  <= 1'b0;
        end else begin
            if (accept) begin
                spec_q  <= spec;
                wr_q    <= wr;
                addr_q  <= addr;
                be_q    <= byte_en;
                wdata_q <= wdata;
            end
            if (capture && !wr_q) begin
                rdata_q <= dram_rd;
                perr_q  <= perr_now;
            end else if (capture) begin
                perr_q  <= 1'b0;
            end
        end
    end

    dsq_fsm #(.PH_W(4), .CONFIRM_PH(3), .CAS_LAST(7)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .spec_q  (spec_q),
        .cpu_as  (cpu_as),
        .stretch (stretch),
        .state   (state),
        .ras_act (ras_act),
        .cas_act (cas_act),
        .col_sel (col_sel),
        .done    (done),
        .killed  (killed),
        .ready   (ready),
        .capture (capture)
    );

    dsq_parity #(.NB(NB)) u_par (
        .wdata   (wdata_q),
        .rd      (dram_rd),
        .rpar    (dram_rpar),
        .lane_en (be_q),
        .wpar    (dram_wpar),
        .err     (perr_now)
    );

    dsq_addr_mux #(.AW(AW)) u_mux (
        .addr_q    (addr_q),
        .col_sel   (col_sel),
        .dram_addr (dram_addr)
    );

    always_comb begin
        ras_n   = !ras_act;
        cas_n   = !cas_act;
        we_n    = ~(be_q & {NB{wr_q & cas_act}});
        dram_wd = wdata_q;
        rdata   = rdata_q;
        par_err = (state == ST_FIN) && !wr_q && perr_q;
    end
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic [NB-1:0] we_n,
    input logic          done,
    input logic          killed,
    input logic          par_err,
    input logic          ready
);
    a_r4_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    a_r5_we_inside_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !(&we_n) |-> !cas_n);
    a_r8_kill_without_cas: assert property (@(posedge clk) disable iff (!rst_n)
        killed |-> (cas_n && (&we_n) && $past(cas_n) && done));
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_perr_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (done && !killed));
    a_r11_precharge_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);
    a_r11_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ras_n && cas_n && !done));
endmodule

bind dram_cycle_seq dsq_checker #(.NB(NB)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .done    (done),
    .killed  (killed),
    .par_err (par_err),
    .ready   (ready)
);

// File: tb/tb_dram_cycle_seq.sv
`timescale 1ns/1ps
module tb_dram_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, spec = 1'b0, wr = 1'b0, cpu_as = 1'b0, stretch = 1'b0;
    logic [17:0] addr = '0;
    logic [3:0]  byte_en = '0;
    logic [31:0] wdata = '0;
    logic        ready, done, killed, par_err, ras_n, cas_n;
    logic [31:0] rdata, dram_wd, dram_rd;
    logic [8:0]  dram_addr;
    logic [3:0]  we_n, dram_wpar, dram_rpar;

    always #5 clk = ~clk;

    dram_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .wr(wr),
        .addr(addr), .byte_en(byte_en), .wdata(wdata), .cpu_as(cpu_as),
        .stretch(stretch), .ready(ready), .done(done), .killed(killed),
        .par_err(par_err), .rdata(rdata), .dram_addr(dram_addr),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dram_wd(dram_wd),
        .dram_wpar(dram_wpar), .dram_rd(dram_rd), .dram_rpar(dram_rpar)
    );

    // DRAM array model
    logic [31:0] mem  [256];
    logic [3:0]  mpar [256];
    logic [3:0]  rowl = '0;
    logic        ras_prev = 1'b1;
    initial for (int i = 0; i < 256; i++) begin mem[i] = '0; mpar[i] = '0; end
    always @(posedge clk) begin
        if (ras_n === 1'b0 && ras_prev === 1'b1) rowl = dram_addr[3:0];
        if (cas_n === 1'b0)
            for (int i = 0; i < 4; i++)
                if (we_n[i] === 1'b0) begin
                    mem[{rowl, dram_addr[3:0]}][8*i +: 8] = dram_wd[8*i +: 8];
                    mpar[{rowl, dram_addr[3:0]}][i] = dram_wpar[i];
                end
        ras_prev = ras_n;
    end
    assign dram_rd   = mem[{rowl, dram_addr[3:0]}];
    assign dram_rpar = mpar[{rowl, dram_addr[3:0]}];

    // Reference model: 0 idle, 1 active, 2 killed, 3 precharge
    int          m_state = 0, mph = 0;
    logic        m_spec = 0, m_wr = 0;
    logic [3:0]  m_be = '0;
    logic [8:0]  m_row = '0, m_col = '0;
    logic [31:0] m_wd = '0, exp_rd = '0;
    logic        exp_pe = 1'b0;
    logic [31:0] shadow [256];
    logic [3:0]  bad [256];
    initial for (int i = 0; i < 256; i++) begin shadow[i] = '0; bad[i] = '0; end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; mph = 0;
        end else begin
            case (m_state)
                0: if (start) begin
                    m_state = 1; mph = 1; m_spec = spec; m_wr = wr; m_be = byte_en;
                    m_row = addr[17:9]; m_col = addr[8:0]; m_wd = wdata;
                end
                1: begin
                    if (mph == 3 && m_spec && !cpu_as) m_state = 2;
                    else if (mph == 7 && stretch) mph = 7;
                    else if (mph == 7) begin
                        exp_rd = shadow[{m_row[3:0], m_col[3:0]}];
                        exp_pe = |(bad[{m_row[3:0], m_col[3:0]}] & m_be);
                        if (m_wr) for (int i = 0; i < 4; i++) if (m_be[i]) begin
                            shadow[{m_row[3:0], m_col[3:0]}][8*i +: 8] = m_wd[8*i +: 8];
                            bad[{m_row[3:0], m_col[3:0]}][i] = 1'b0;
                        end
                        mph = 8;
                    end
                    else if (mph == 8) m_state = 3;
                    else mph = mph + 1;
                end
                2: m_state = 3;
                default: m_state = 0;
            endcase
        end
    end

    int nchk = 0, nerr = 0, cas_cnt = 0, done_cnt = 0;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            logic act, casa;
            act  = (m_state == 1) && (mph <= 7);
            casa = (m_state == 1) && (mph >= 4) && (mph <= 7);
            if (cas_n === 1'b0) cas_cnt++;
            if (done === 1'b1) done_cnt++;
            chk("R2 ras_n", 64'(ras_n), 64'(!act));
            chk("R4 cas_n", 64'(cas_n), 64'(!casa));
            for (int i = 0; i < 4; i++)
                chk("R5 we_n", 64'(we_n[i]), 64'(!(casa && m_wr && m_be[i])));
            chk("R2/R8 done", 64'(done), 64'(((m_state == 1) && (mph == 8)) || (m_state == 2)));
            chk("R8 killed", 64'(killed), 64'(m_state == 2));
            chk("R11 ready", 64'(ready), 64'(m_state == 0));
            chk("R7 par_err", 64'(par_err), 64'((m_state == 1) && (mph == 8) && !m_wr && exp_pe));
            if (act) chk("R3 dram_addr", 64'(dram_addr), 64'((mph <= 2) ? m_row : m_col));
            if (casa && m_wr)
                for (int i = 0; i < 4; i++)
                    chk("R6 dram_wpar", 64'(dram_wpar[i]), 64'(^m_wd[8*i +: 8]));
            if (m_state == 1 && mph == 8 && !m_wr) chk("R7 rdata", 64'(rdata), 64'(exp_rd));
        end
    end

    task automatic access(input bit sp, input bit w, input logic [3:0] row, input logic [3:0] col,
                          input logic [3:0] be, input logic [31:0] d, input bit as_v, input int st);
        @(negedge clk);
        start = 1; spec = sp; wr = w; addr = {5'b0, row, 5'b0, col};
        byte_en = be; wdata = d; cpu_as = as_v;
        @(negedge clk);
        start = 0;
        if (st > 0) begin
            while (!(m_state == 1 && mph == 7)) @(negedge clk);
            stretch = 1;
            repeat (st) @(negedge clk);
            stretch = 0;
        end
        while (m_state != 0) @(negedge clk);
        cpu_as = 0;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nerr++;
            $display("FAIL watchdog: got %0d expected <100000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 64'(ready), 64'd1);
        chk("R1 ras_n", 64'(ras_n), 64'd1);
        chk("R1 cas_n", 64'(cas_n), 64'd1);
        chk("R1 we_n", 64'(we_n), 64'hF);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 par_err", 64'(par_err), 64'd0);

        access(0, 1, 4'd3, 4'd5, 4'hF, 32'hA5C3_0F81, 0, 0);
        access(0, 0, 4'd3, 4'd5, 4'hF, 32'h0, 0, 0);
        chk("R7 readback", 64'(rdata), 64'hA5C3_0F81);
        access(0, 1, 4'd3, 4'd5, 4'b0101, 32'h1122_3344, 0, 0);
        access(0, 0, 4'd3, 4'd5, 4'hF, 32'h0, 0, 0);
        chk("R5 lane merge", 64'(rdata), 64'hA522_0F44);

        access(1, 1, 4'd1, 4'd2, 4'hF, 32'hDEAD_BEEF, 1, 0);
        access(0, 0, 4'd1, 4'd2, 4'hF, 32'h0, 0, 0);
        chk("R9 confirmed write", 64'(rdata), 64'hDEAD_BEEF);
        access(1, 1, 4'd1, 4'd2, 4'hF, 32'h0, 0, 0);
        access(1, 0, 4'd3, 4'd5, 4'hF, 32'h0, 0, 0);
        access(0, 0, 4'd1, 4'd2, 4'hF, 32'h0, 0, 0);
        chk("R8 killed write no effect", 64'(rdata), 64'hDEAD_BEEF);

        cas_cnt = 0;
        access(0, 0, 4'd3, 4'd5, 4'hF, 32'h0, 0, 3);
        chk("R10 stretched cas phases", 64'(cas_cnt), 64'd7);
        cas_cnt = 0;
        access(1, 0, 4'd3, 4'd5, 4'hF, 32'h0, 1, 2);
        chk("R10 R9 stretched confirmed", 64'(cas_cnt), 64'd6);

        mpar[{4'd3, 4'd5}][2] = ~mpar[{4'd3, 4'd5}][2];
        bad[{4'd3, 4'd5}][2] = 1'b1;
        access(0, 0, 4'd3, 4'd5, 4'hF, 32'h0, 0, 0);
        access(0, 0, 4'd3, 4'd5, 4'b1011, 32'h0, 0, 0);

        // R11 start ignored while busy
        @(negedge clk);
        start = 1; spec = 0; wr = 0; addr = {5'b0, 4'd3, 5'b0, 4'd5}; byte_en = 4'hF;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        start = 1; wr = 1; addr = {5'b0, 4'd1, 5'b0, 4'd2}; wdata = 32'h0;
        repeat (2) @(negedge clk);
        start = 0; wr = 0;
        while (m_state != 0) @(negedge clk);
        access(0, 0, 4'd1, 4'd2, 4'hF, 32'h0, 0, 0);
        chk("R11 busy start ignored", 64'(rdata), 64'hDEAD_BEEF);

        // R11 start held high: one access every ten phases
        @(negedge clk);
        done_cnt = 0;
        start = 1; spec = 0; wr = 0; addr = {5'b0, 4'd3, 5'b0, 4'd5};
        repeat (30) @(negedge clk);
        start = 0;
        chk("R11 held start completions", 64'(done_cnt), 64'd3);
        while (m_state != 0) @(negedge clk);
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule